// File: doc/BRIEF.md
# Jump and Call Program-Counter Sequencer

This block takes over once an 8-bit CPU core has decoded a jump or a subroutine call and fetched its operand bytes. It produces the new 16-bit program counter and the new stack pointer, and it raises a one-cycle completion strobe. On a call it first stores the return address on the stack, high byte then low byte, and lowers the stack pointer by one after each byte. Only after both bytes are stored does it form the destination.

The destination comes from one of four modes. Absolute mode uses the operand bytes directly. Indirect-absolute mode reads the destination from a full 16-bit pointer. Zero-page indirect mode reads it from a pointer in page zero. Special-page mode takes the low byte from the operand and forces the high byte to all ones. Each legal pairing of kind and mode has its own fixed cycle count. The core issues a request with a one-cycle `start` and then waits for `done`. Memory is reached through a single byte-wide port whose read data is combinational on the address.

Top module: `pc_branch_seq`

## Requirements
- R1: While reset is active and until the first accepted request, `done`, `mem_we` and `mem_re` are 0, and `pc_out` and `sp_out` are 0.
- R2: A jump (`kind`=0) in absolute mode (`mode`=0) gives `pc_out` = {`adh`,`adl`}.
- R3: A jump in indirect-absolute mode (`mode`=1) reads the low destination byte at {`adh`,`adl`}, then the high byte at {`adh`,`adl`}+1. The increment is 16 bits wide, so it carries into the high byte. `pc_out` = {second byte, first byte}.
- R4: Zero-page indirect mode (`mode`=2), for a jump or a call, reads the low byte at {00,`adl`}, then the high byte at {00,`adl`+1}. The increment wraps within page 00.
- R5: A call (`kind`=1) writes `ret_pc[15:8]` to {01,S}, then `ret_pc[7:0]` to {01,S-1}. S is `sp_in`, and the 8-bit arithmetic wraps. It then reports `sp_out` = S-2. A call also accepts absolute mode (`mode`=0), giving `pc_out` = {`adh`,`adl`}.
- R6: A call in special-page mode (`mode`=3) gives `pc_out` = {FF,`adl`}.
- R7: `done` rises N-1 rising edges after the edge that samples `start`. N is 3 for an absolute jump, 5 for an indirect jump, 4 for a zero-page indirect jump, 6 for an absolute call, 5 for a special-page call and 7 for a zero-page indirect call.
- R8: A jump performs no memory writes and reports `sp_out` = `sp_in`. Memory reads occur only in the indirect modes, and never in the same cycle as a write.
- R9: A `start` that arrives while a request is in progress has no effect. A `start` carrying a jump with `mode`=3 or a call with `mode`=1 is ignored.
- R10: A `start` that arrives in the same cycle as `done` is accepted. The new request then completes with its own timing and results.
- R11: `done` lasts exactly one cycle. `pc_out` changes only when `done` rises, and it then holds its value until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request strobe |
| kind | input | 1 | 0 = jump, 1 = call |
| mode | input | 2 | 0 absolute, 1 indirect absolute, 2 zero-page indirect, 3 special page |
| adl | input | 8 | Operand low byte |
| adh | input | 8 | Operand high byte |
| ret_pc | input | 16 | Return address to be stored by a call |
| sp_in | input | 8 | Current stack pointer |
| mem_rdata | input | 8 | Memory read data, combinational on `mem_addr` |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| pc_out | output | 16 | New program counter |
| sp_out | output | 8 | New stack pointer |
| done | output | 1 | Completion strobe |

## Verification
Two events can land in the same cycle: the completion of one request and the acceptance of the next. The bench provokes this by raising `start` in the very cycle in which `done` is seen. It then judges the second request on its own cycle count, pushes, reads and destination, and checks that the first result was presented for exactly one cycle. A second overlap is a `start` that arrives in the middle of a call. That case is judged by confirming that the running call completes with its original timing, stack writes and destination.

// File: rtl/pcseq_pkg.sv
`timescale 1ns/1ps
package pcseq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_PUSH_H, PH_PUSH_L, PH_RD_LO, PH_RD_HI, PH_WAIT, PH_FIN
  } phase_t;

  localparam logic [1:0] MD_ABS = 2'd0;
  localparam logic [1:0] MD_IND = 2'd1;
  localparam logic [1:0] MD_ZPI = 2'd2;
  localparam logic [1:0] MD_SPG = 2'd3;
endpackage

// File: rtl/pcseq_decode.sv
`timescale 1ns/1ps
module pcseq_decode import pcseq_pkg::*; #(
  parameter int CW          = 4,
  parameter int CYC_JMP_ABS = 3,
  parameter int CYC_JMP_IND = 5,
  parameter int CYC_JMP_ZPI = 4,
  parameter int CYC_JSR_ABS = 6,
  parameter int CYC_JSR_SPG = 5,
  parameter int CYC_JSR_ZPI = 7
) (
  input  logic          kind,
  input  logic [1:0]    mode,
  output logic          valid,
  output logic [CW-1:0] mid_cnt,
  output phase_t        first_ph
);
  // middle cycles = total minus the start cycle and the finish cycle
  localparam logic [CW-1:0] M_JA = CW'(CYC_JMP_ABS - 2);
  localparam logic [CW-1:0] M_JI = CW'(CYC_JMP_IND - 2);
  localparam logic [CW-1:0] M_JZ = CW'(CYC_JMP_ZPI - 2);
  localparam logic [CW-1:0] M_CA = CW'(CYC_JSR_ABS - 2);
  localparam logic [CW-1:0] M_CS = CW'(CYC_JSR_SPG - 2);
  localparam logic [CW-1:0] M_CZ = CW'(CYC_JSR_ZPI - 2);

  logic needs_rd;

  always_comb begin
    valid   = 1'b1;
    mid_cnt = '0;
    case ({kind, mode})
      {1'b0, MD_ABS}: mid_cnt = M_JA;
      {1'b0, MD_IND}: mid_cnt = M_JI;
      {1'b0, MD_ZPI}: mid_cnt = M_JZ;
      {1'b1, MD_ABS}: mid_cnt = M_CA;
      {1'b1, MD_ZPI}: mid_cnt = M_CZ;
      {1'b1, MD_SPG}: mid_cnt = M_CS;
      default:        valid   = 1'b0;
    endcase
  end

  assign needs_rd = (mode == MD_IND) || (mode == MD_ZPI);

  always_comb begin
    if (kind)          first_ph = PH_PUSH_H;
    else if (needs_rd) first_ph = PH_RD_LO;
    else               first_ph = PH_WAIT;
  end
endmodule

// File: rtl/pcseq_addr.sv
`timescale 1ns/1ps
module pcseq_addr import pcseq_pkg::*; #(
  parameter logic [7:0] STACK_PAGE = 8'h01
) (
  input  phase_t      ph,
  input  logic        ind_abs,
  input  logic [7:0]  sp,
  input  logic [7:0]  adl,
  input  logic [7:0]  adh,
  input  logic [15:0] ret,
  output logic [15:0] addr,
  output logic [7:0]  wdata,
  output logic        we,
  output logic        re
);
  logic [15:0] ptr_lo, ptr_hi;

  assign ptr_lo = ind_abs ? {adh, adl} : {8'h00, adl};
  assign ptr_hi = ind_abs ? ({adh, adl} + 16'd1) : {8'h00, adl + 8'd1};

  always_comb begin
    addr  = '0;
    wdata = '0;
    we    = 1'b0;
    re    = 1'b0;
    case (ph)
      PH_PUSH_H: begin addr = {STACK_PAGE, sp}; wdata = ret[15:8]; we = 1'b1; end
      PH_PUSH_L: begin addr = {STACK_PAGE, sp}; wdata = ret[7:0];  we = 1'b1; end
      PH_RD_LO:  begin addr = ptr_lo; re = 1'b1; end
      PH_RD_HI:  begin addr = ptr_hi; re = 1'b1; end
      default:   ;
    endcase
  end
endmodule

// File: rtl/pc_branch_seq.sv
`timescale 1ns/1ps
module pc_branch_seq import pcseq_pkg::*; #(
  parameter int         CW           = 4,
  parameter logic [7:0] STACK_PAGE   = 8'h01,
  parameter logic [7:0] SPECIAL_PAGE = 8'hFF,
  parameter int         CYC_JMP_ABS  = 3,
  parameter int         CYC_JMP_IND  = 5,
  parameter int         CYC_JMP_ZPI  = 4,
  parameter int         CYC_JSR_ABS  = 6,
  parameter int         CYC_JSR_SPG  = 5,
  parameter int         CYC_JSR_ZPI  = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        kind,
  input  logic [1:0]  mode,
  input  logic [7:0]  adl,
  input  logic [7:0]  adh,
  input  logic [15:0] ret_pc,
  input  logic [7:0]  sp_in,
  input  logic [7:0]  mem_rdata,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  output logic        mem_we,
  output logic        mem_re,
  output logic [15:0] pc_out,
  output logic [7:0]  sp_out,
  output logic        done
);
  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_n, rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_s_n    <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_s_n    <= rst_meta_n;
    end
  end

  phase_t        ph_q, ph_n, dec_first;
  logic [CW-1:0] cnt_q, cnt_n, dec_cnt;
  logic [7:0]    sp_q, sp_n, adl_q, adh_q, lo_q, hi_q, hi_byte;
  logic [15:0]   pc_q, target, ret_q;
  logic [1:0]    md_q;
  logic          dec_valid, accept, middle, last;
  logic          op_en, sp_en, lo_en, hi_en, pc_en;

  pcseq_decode #(
    .CW(CW), .CYC_JMP_ABS(CYC_JMP_ABS), .CYC_JMP_IND(CYC_JMP_IND),
    .CYC_JMP_ZPI(CYC_JMP_ZPI), .CYC_JSR_ABS(CYC_JSR_ABS),
    .CYC_JSR_SPG(CYC_JSR_SPG), .CYC_JSR_ZPI(CYC_JSR_ZPI)
  ) u_dec (
    .kind(kind), .mode(mode), .valid(dec_valid),
    .mid_cnt(dec_cnt), .first_ph(dec_first)
  );

  pcseq_addr #(.STACK_PAGE(STACK_PAGE)) u_addr (
    .ph(ph_q), .ind_abs(md_q == MD_IND), .sp(sp_q), .adl(adl_q), .adh(adh_q),
    .ret(ret_q), .addr(mem_addr), .wdata(mem_wdata), .we(mem_we), .re(mem_re)
  );

  // next-state logic
  assign middle  = (ph_q != PH_IDLE) && (ph_q != PH_FIN);
  assign accept  = !middle && start && dec_valid;
  assign last    = middle && (cnt_q == CW'(1));
  assign hi_byte = (ph_q == PH_RD_HI) ? mem_rdata : hi_q;

  always_comb begin
    case (md_q)
      MD_SPG:         target = {SPECIAL_PAGE, adl_q};
      MD_IND, MD_ZPI: target = {hi_byte, lo_q};
      default:        target = {adh_q, adl_q};
    endcase
  end

  always_comb begin
    ph_n  = ph_q;
    cnt_n = cnt_q;
    if (accept) begin
      ph_n  = dec_first;
      cnt_n = dec_cnt;
    end else if (!middle) begin
      ph_n  = PH_IDLE;
    end else begin
      cnt_n = cnt_q - CW'(1);
      if (last) ph_n = PH_FIN;
      else begin
        case (ph_q)
          PH_PUSH_H: ph_n = PH_PUSH_L;
          PH_PUSH_L: ph_n = ((md_q == MD_IND) || (md_q == MD_ZPI)) ? PH_RD_LO : PH_WAIT;
          PH_RD_LO:  ph_n = PH_RD_HI;
          default:   ph_n = PH_WAIT;
        endcase
      end
    end
  end

  assign op_en = accept;
  assign sp_en = accept || (ph_q == PH_PUSH_H) || (ph_q == PH_PUSH_L);
  assign sp_n  = accept ? sp_in : (sp_q - 8'd1);
  assign lo_en = (ph_q == PH_RD_LO);
  assign hi_en = (ph_q == PH_RD_HI);
  assign pc_en = last;

  // registers
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      sp_q  <= '0;
      pc_q  <= '0;
      adl_q <= '0;
      adh_q <= '0;
      ret_q <= '0;
      md_q  <= MD_ABS;
      lo_q  <= '0;
      hi_q  <= '0;
    end else begin
      ph_q  <= ph_n;
      cnt_q <= cnt_n;
      if (sp_en) sp_q <= sp_n;
      if (op_en) begin
        adl_q <= adl;
        adh_q <= adh;
        ret_q <= ret_pc;
        md_q  <= mode;
      end
      if (lo_en) lo_q <= mem_rdata;
      if (hi_en) hi_q <= mem_rdata;
      if (pc_en) pc_q <= target;
    end
  end

  assign pc_out = pc_q;
  assign sp_out = sp_q;
  assign done   = (ph_q == PH_FIN);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_s_n)
    done |=> !done); // R11
  AST_PC_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_s_n)
    !$stable(pc_out) |-> done); // R11
  AST_PUSH_IN_STACK: assert property (@(posedge clk) disable iff (!rst_s_n)
    mem_we |-> (mem_addr[15:8] == STACK_PAGE)); // R5
  AST_PUSH_DECREMENT: assert property (@(posedge clk) disable iff (!rst_s_n)
    mem_we |=> (sp_out == $past(sp_out) - 8'd1)); // R5
  AST_RW_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_s_n)
    !(mem_we && mem_re)); // R8
  AST_START_BUSY_IGNORED: assert property (@(posedge clk) disable iff (!rst_s_n)
    (start && middle && !last) |=> !done); // R9
endmodule

// File: tb/sim_pc_branch_seq.sv
`timescale 1ns/1ps
module sim_pc_branch_seq;
  logic        clk = 1'b0;
  logic        rst_n, start, kind;
  logic [1:0]  mode;
  logic [7:0]  adl, adh, sp_in, mem_rdata, mem_wdata, sp_out;
  logic [15:0] ret_pc, mem_addr, pc_out;
  logic        mem_we, mem_re, done;
  int          total = 0, bad = 0;
  bit          finished = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  pc_branch_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .kind(kind), .mode(mode),
    .adl(adl), .adh(adh), .ret_pc(ret_pc), .sp_in(sp_in), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .pc_out(pc_out), .sp_out(sp_out), .done(done)
  );

  function automatic logic [7:0] mf(input logic [15:0] a);
    return a[7:0] ^ {a[14:8], 1'b0} ^ 8'h3C;
  endfunction
  assign mem_rdata = mf(mem_addr);

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic run_op(input string nm, input string pctag, input logic k,
                        input logic [1:0] m, input logic [7:0] l, input logic [7:0] h,
                        input logic [15:0] r, input logic [7:0] s,
                        input int exp_cyc, input bit inject);
    int cyc = 0, nw = 0, nr = 0;
    logic [15:0] wa[4], ra[4], a0, a1, exp_pc;
    logic [7:0]  wd[4], exp_sp;
    kind = k; mode = m; adl = l; adh = h; ret_pc = r; sp_in = s; start = 1'b1;
    while (cyc < 20) begin
      @(posedge clk); @(negedge clk); cyc++;
      start = 1'b0;
      if (inject && cyc == 1) begin
        start = 1'b1; kind = 1'b1; mode = 2'd0; adl = 8'h77; adh = 8'h66;
        ret_pc = 16'h1111; sp_in = 8'h10;
      end
      if (mem_we && nw < 4) begin wa[nw] = mem_addr; wd[nw] = mem_wdata; nw++; end
      if (mem_re && nr < 4) begin ra[nr] = mem_addr; nr++; end
      if (done) break;
    end
    a0 = (m == 2'd1) ? {h, l} : {8'h00, l};
    a1 = (m == 2'd1) ? ({h, l} + 16'd1) : {8'h00, l + 8'd1};
    case (m)
      2'd0:    exp_pc = {h, l};
      2'd3:    exp_pc = {8'hFF, l};
      default: exp_pc = {mf(a1), mf(a0)};
    endcase
    exp_sp = k ? (s - 8'd2) : s;
    check(cyc == exp_cyc - 1, "R7", {nm, " cycle count"}, cyc, exp_cyc - 1);
    check(pc_out == exp_pc, pctag, {nm, " pc"}, pc_out, exp_pc);
    check(sp_out == exp_sp, k ? "R5" : "R8", {nm, " sp"}, sp_out, exp_sp);
    if (k) begin
      check(nw == 2, "R5", {nm, " push count"}, nw, 2);
      check(nw == 2 && wa[0] == {8'h01, s} && wd[0] == r[15:8], "R5",
            {nm, " first push addr/data"}, {wa[0], wd[0]}, {8'h01, s, r[15:8]});
      check(nw == 2 && wa[1] == {8'h01, s - 8'd1} && wd[1] == r[7:0], "R5",
            {nm, " second push addr/data"}, {wa[1], wd[1]}, {8'h01, s - 8'd1, r[7:0]});
    end else begin
      check(nw == 0, "R8", {nm, " no writes on jump"}, nw, 0);
    end
    if (m == 2'd1 || m == 2'd2) begin
      check(nr == 2 && ra[0] == a0 && ra[1] == a1, (m == 2'd1) ? "R3" : "R4",
            {nm, " pointer reads"}, {ra[0], ra[1]}, {a0, a1});
    end else begin
      check(nr == 0, "R8", {nm, " no reads"}, nr, 0);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start = 1'b0; kind = 1'b0; mode = 2'd0; adl = '0; adh = '0;
    ret_pc = '0; sp_in = '0;
    repeat (3) @(negedge clk);
    check(!done && !mem_we && !mem_re && pc_out == 16'h0 && sp_out == 8'h0, "R1",
          "reset outputs", {done, mem_we, mem_re, pc_out, sp_out}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!done && !mem_we && !mem_re && pc_out == 16'h0, "R1", "idle after reset",
          {done, mem_we, mem_re, pc_out}, 0);
  endtask

  task automatic t_jumps();
    run_op("jmp abs", "R2", 1'b0, 2'd0, 8'h34, 8'h12, 16'hAAAA, 8'h80, 3, 1'b0);
    @(negedge clk);
    run_op("jmp ind carry", "R3", 1'b0, 2'd1, 8'hFF, 8'h20, 16'hAAAA, 8'h80, 5, 1'b0);
    @(negedge clk);
    run_op("jmp zpi wrap", "R4", 1'b0, 2'd2, 8'hFF, 8'h55, 16'hAAAA, 8'h40, 4, 1'b0);
    @(negedge clk);
  endtask

  task automatic t_calls();
    run_op("jsr abs", "R5", 1'b1, 2'd0, 8'hCD, 8'hAB, 16'h1234, 8'hFF, 6, 1'b0);
    @(negedge clk);
    run_op("jsr special", "R6", 1'b1, 2'd3, 8'h9E, 8'h00, 16'hBEEF, 8'h7F, 5, 1'b0);
    @(negedge clk);
    run_op("jsr zpi sp wrap", "R4", 1'b1, 2'd2, 8'h10, 8'hEE, 16'hC0DE, 8'h00, 7, 1'b0);
    @(negedge clk);
  endtask

  task automatic t_busy_start();
    run_op("R9 jsr with start while busy", "R9", 1'b1, 2'd0, 8'h21, 8'h43, 16'h5566,
           8'hF0, 6, 1'b1);
    @(negedge clk);
    check(!done, "R9", "no extra completion after busy start", done, 0);
  endtask

  task automatic t_illegal();
    logic [15:0] pc0;
    pc0 = pc_out;
    kind = 1'b0; mode = 2'd3; adl = 8'h11; adh = 8'h22; start = 1'b1;
    @(negedge clk); start = 1'b0;
    kind = 1'b1; mode = 2'd1; start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < 8; i++) begin
      check(!done && !mem_we && !mem_re && pc_out == pc0, "R9", "illegal pair ignored",
            {done, mem_we, mem_re, pc_out}, {3'b000, pc0});
      @(negedge clk);
    end
  endtask

  task automatic t_back_to_back();
    logic [15:0] pc1;
    run_op("R10 first", "R2", 1'b0, 2'd0, 8'h01, 8'h90, 16'h0, 8'h33, 3, 1'b0);
    pc1 = pc_out;
    run_op("R10 second", "R10", 1'b1, 2'd2, 8'h80, 8'h00, 16'h4321, 8'h33, 7, 1'b0);
    check(pc1 == 16'h9001, "R10", "first result before chaining", pc1, 16'h9001);
  endtask

  task automatic t_hold();
    logic [15:0] pc1;
    @(negedge clk);
    pc1 = pc_out;
    check(!done, "R11", "done lasts one cycle", done, 0);
    repeat (5) @(negedge clk);
    check(pc_out == pc1 && !done, "R11", "pc holds while idle", pc_out, pc1);
  endtask

  initial begin
    t_reset();
    t_jumps();
    t_calls();
    t_busy_start();
    t_illegal();
    t_back_to_back();
    t_hold();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule